// File: doc/BRIEF.md
# Processor Halt and Wakeup Controller

This block decides when a small processor pipeline may run. When reset ends it reads a two-bit boot-mode input and takes one of three paths: start fetching at a fixed base vector, go straight to sleep, or stop in a debug halt. On the sleep and debug-halt paths it touches no bus. A boot sleep ends when a wakeup input is seen, and a debug halt ends with a debug-continue pulse. In both cases execution then starts at the base vector.

While the pipeline runs, software can ask it to sleep. The request carries a kind code (plain sleep, hibernate or suspend) and the address of the next instruction. The controller drops the run enable at once. It then waits until a counter of outstanding external accesses reads zero, and only then raises the one status flag that matches the kind. A wakeup restarts fetch at the captured address. Separately, a level-sensitive pause input stalls the pipeline under hardware control.

The raw reset input and the two wakeup inputs pass through flip-flop synchronizer chains. The chain lengths are parameters, and a length of zero makes the input pass straight through.

Top module: `halt_wake_ctrl`

## Requirements
- R1: With boot mode 2'b00 or 2'b11, the first cycle after reset takes effect sets run_o and fetch_start_o together, with fetch_addr_o equal to BASE_VECTOR.
- R2: With boot mode 2'b01, the controller raises sleep_o and keeps run_o and fetch_start_o low after reset. Once either bit of wake_i is seen, it starts at BASE_VECTOR.
- R3: With boot mode 2'b10 and DBG_EN=1, the controller raises halted_o and stays halted until dbg_continue_i, which starts execution at BASE_VECTOR. With DBG_EN=0, mode 2'b10 behaves as R1.
- R4: A sleep request (sleep_req_i) drops run_o in the next cycle. No sleep flag rises while the outstanding-access count is nonzero. The count goes up for each acc_req_i and down for each acc_rsp_i.
- R5: After the drain, exactly one flag is set according to sleep_kind_i: 2'b00 gives sleep_o, 2'b01 gives hibernate_o, 2'b10 gives suspend_o, and 2'b11 is treated as 2'b00.
- R6: A wakeup from a software sleep starts fetch at the resume_addr_i captured with the request. All sleep flags clear in the same cycle run_o rises.
- R7: While running, pause_i high halts the pipeline one cycle later with paused_o set, and keeps it halted while the input stays high. Releasing pause_i resumes the pipeline without a fetch strobe.
- R8: pause_i has no effect during sleep. If pause_i is high when a wakeup arrives, the sleep flags clear and paused_o rises. The pending start then issues its strobe when pause_i falls.
- R9: fetch_start_o is a single-cycle pulse, issued once per start and always alongside run_o.
- R10: The reset input and the wakeup inputs take effect after their synchronizer depth plus one clock edge. With the default depth of 2, that is three edges.
- R11: dbg_continue_i has no effect unless the controller is in debug halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset request, synchronized inside |
| boot_mode_i | input | 2 | Boot path selected when reset ends |
| wake_i | input | 2 | Asynchronous wakeup requests |
| sleep_req_i | input | 1 | Software sleep request pulse |
| sleep_kind_i | input | 2 | Sleep kind code qualifying sleep_req_i |
| resume_addr_i | input | ADDR_W | Address of the instruction after the sleep request |
| pause_i | input | 1 | Hardware pause level |
| dbg_continue_i | input | 1 | Debug continue pulse |
| acc_req_i | input | 1 | An external access was accepted |
| acc_rsp_i | input | 1 | An external access completed |
| run_o | output | 1 | Pipeline run enable |
| fetch_start_o | output | 1 | Single-cycle fetch start strobe |
| fetch_addr_o | output | ADDR_W | Start address qualified by fetch_start_o |
| sleep_o | output | 1 | Sleeping, plain kind |
| hibernate_o | output | 1 | Sleeping, hibernate kind |
| suspend_o | output | 1 | Sleeping, suspend kind |
| paused_o | output | 1 | Halted by pause_i |
| halted_o | output | 1 | In debug halt |

## Verification
The checker assumes that the pipeline side never accepts an access while run_o is low. It also assumes that a response never arrives with nothing outstanding, so the access counter cannot underflow. The bench keeps to these assumptions: it pulses acc_req_i only while the pipeline runs, and it sends exactly as many responses as it issued requests, one per cycle. It also drops wake_i once a start has been observed and waits a few cycles before the next sleep request, so the synchronizer never carries a stale wakeup into a new sleep.

// File: rtl/hwc_pkg.sv
// Shared types for the halt and wakeup controller.
// Assumes a two-bit kind code in which 2'b11 is folded onto plain sleep.
package hwc_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_RUN,
        ST_DRAIN,
        ST_SLEEP,
        ST_PAUSE,
        ST_DHALT
    } hwc_state_e;

    typedef enum logic [1:0] {
        KIND_SLEEP     = 2'b00,
        KIND_HIBERNATE = 2'b01,
        KIND_SUSPEND   = 2'b10
    } hwc_kind_e;

    // Map a raw request code to a legal kind.
    function automatic hwc_kind_e to_kind(input logic [1:0] code);
        return (code == 2'b11) ? KIND_SLEEP : hwc_kind_e'(code);
    endfunction

endpackage

// File: rtl/hwc_sync.sv
// Flip-flop synchronizer chain of STAGES flops for a WIDTH-bit bus.
// With STAGES of 0 the input is assumed synchronous and is passed through.
// The flops carry no reset, since they must also carry the reset input itself.
module hwc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];
            for (genvar s = 0; s < STAGES; s++) begin : g_stage
                // Move the sample one flop further along the chain.
                always_ff @(posedge clk_i) begin
                    if (s == 0) stage_q[s] <= d_i;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
            assign q_o = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hwc_acc_track.sv
// Counts the external accesses that have been accepted but have not completed.
// Assumes the count never exceeds MAX_OUTSTANDING and never underflows.
module hwc_acc_track #(
    parameter int MAX_OUTSTANDING = 7,
    localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             rsp_i,
    output logic [CNT_W-1:0] count_o,
    output logic             idle_o
);
    logic [CNT_W-1:0] count_q;

    // Add one per accept and subtract one per response; both at once cancel.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)              count_q <= '0;
        else if (req_i && !rsp_i) count_q <= count_q + 1'b1;
        else if (rsp_i && !req_i) count_q <= count_q - 1'b1;
    end

    assign count_o = count_q;
    assign idle_o  = (count_q == '0);
endmodule

// File: rtl/hwc_fsm.sv
// Run/halt sequencer: boot path choice, sleep drain, pause and debug halt.
// All outputs come from registers. A start that meets a high pause level is
// held pending and issues its strobe when the pause ends.
module hwc_fsm
    import hwc_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] BASE_VECTOR = '0,
    parameter bit              DBG_EN      = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        boot_mode_i,
    input  logic              wake_any_i,
    input  logic              sleep_req_i,
    input  logic [1:0]        sleep_kind_i,
    input  logic [ADDR_W-1:0] resume_addr_i,
    input  logic              pause_i,
    input  logic              dbg_continue_i,
    input  logic              idle_i,
    output logic              run_o,
    output logic              fetch_start_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              sleep_o,
    output logic              hibernate_o,
    output logic              suspend_o,
    output logic              paused_o,
    output logic              halted_o
);
    hwc_state_e        state_q, state_d;
    hwc_kind_e         kind_q, kind_d;
    logic [ADDR_W-1:0] tgt_q, tgt_d, addr_q;
    logic              pend_q, pend_d, launch, go, fetch_q;

    // Next state, captured target and start decision.
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        tgt_d   = tgt_q;
        pend_d  = pend_q;
        go      = 1'b0;
        launch  = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                tgt_d = BASE_VECTOR;
                if (boot_mode_i == 2'b01) begin
                    state_d = ST_SLEEP;
                    kind_d  = KIND_SLEEP;
                end else if (boot_mode_i == 2'b10 && DBG_EN) begin
                    state_d = ST_DHALT;
                end else begin
                    go = 1'b1;
                end
            end
            ST_RUN: begin
                if (sleep_req_i) begin
                    state_d = ST_DRAIN;
                    kind_d  = to_kind(sleep_kind_i);
                    tgt_d   = resume_addr_i;
                end else if (pause_i) begin
                    state_d = ST_PAUSE;
                end
            end
            ST_DRAIN: if (idle_i) state_d = ST_SLEEP;
            ST_SLEEP: go = wake_any_i;
            ST_DHALT: go = dbg_continue_i;
            ST_PAUSE: begin
                if (!pause_i) begin
                    state_d = ST_RUN;
                    launch  = pend_q;
                    pend_d  = 1'b0;
                end
            end
            default: state_d = ST_BOOT;
        endcase
        if (go) begin
            if (pause_i) begin
                state_d = ST_PAUSE;
                pend_d  = 1'b1;
            end else begin
                state_d = ST_RUN;
                launch  = 1'b1;
            end
        end
    end

    // Register state, captured target and the strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_BOOT;
            kind_q  <= KIND_SLEEP;
            tgt_q   <= BASE_VECTOR;
            pend_q  <= 1'b0;
            fetch_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            tgt_q   <= tgt_d;
            pend_q  <= pend_d;
            fetch_q <= launch;
            if (launch) addr_q <= tgt_d;
        end
    end

    assign run_o         = (state_q == ST_RUN);
    assign fetch_start_o = fetch_q;
    assign fetch_addr_o  = addr_q;
    assign sleep_o       = (state_q == ST_SLEEP) && (kind_q == KIND_SLEEP);
    assign hibernate_o   = (state_q == ST_SLEEP) && (kind_q == KIND_HIBERNATE);
    assign suspend_o     = (state_q == ST_SLEEP) && (kind_q == KIND_SUSPEND);
    assign paused_o      = (state_q == ST_PAUSE);
    assign halted_o      = (state_q == ST_DHALT);
endmodule

// File: rtl/halt_wake_ctrl.sv
// Top of the halt and wakeup controller. It synchronizes reset and wakeups,
// tracks the outstanding accesses and sequences run, sleep, pause and debug halt.
// Assumes that acc_req_i is only asserted while run_o is high.
module halt_wake_ctrl #(
    parameter int                ADDR_W           = 32,
    parameter logic [ADDR_W-1:0] BASE_VECTOR      = 32'h0000_0100,
    parameter bit                DBG_EN           = 1'b1,
    parameter int                RST_SYNC_STAGES  = 2,
    parameter int                WAKE_SYNC_STAGES = 2,
    parameter int                MAX_OUTSTANDING  = 7,
    localparam int               CNT_W            = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        boot_mode_i,
    input  logic [1:0]        wake_i,
    input  logic              sleep_req_i,
    input  logic [1:0]        sleep_kind_i,
    input  logic [ADDR_W-1:0] resume_addr_i,
    input  logic              pause_i,
    input  logic              dbg_continue_i,
    input  logic              acc_req_i,
    input  logic              acc_rsp_i,
    output logic              run_o,
    output logic              fetch_start_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              sleep_o,
    output logic              hibernate_o,
    output logic              suspend_o,
    output logic              paused_o,
    output logic              halted_o
);
    logic             rst_n_s;
    logic [1:0]       wake_s;
    logic [CNT_W-1:0] acc_cnt;
    logic             acc_idle;

    hwc_sync #(.WIDTH(1), .STAGES(RST_SYNC_STAGES)) u_rst_sync (
        .clk_i (clk_i),
        .d_i   (rst_ni),
        .q_o   (rst_n_s)
    );

    hwc_sync #(.WIDTH(2), .STAGES(WAKE_SYNC_STAGES)) u_wake_sync (
        .clk_i (clk_i),
        .d_i   (wake_i),
        .q_o   (wake_s)
    );

    hwc_acc_track #(.MAX_OUTSTANDING(MAX_OUTSTANDING)) u_track (
        .clk_i   (clk_i),
        .rst_ni  (rst_n_s),
        .req_i   (acc_req_i),
        .rsp_i   (acc_rsp_i),
        .count_o (acc_cnt),
        .idle_o  (acc_idle)
    );

    hwc_fsm #(.ADDR_W(ADDR_W), .BASE_VECTOR(BASE_VECTOR), .DBG_EN(DBG_EN)) u_fsm (
        .clk_i          (clk_i),
        .rst_ni         (rst_n_s),
        .boot_mode_i    (boot_mode_i),
        .wake_any_i     (|wake_s),
        .sleep_req_i    (sleep_req_i),
        .sleep_kind_i   (sleep_kind_i),
        .resume_addr_i  (resume_addr_i),
        .pause_i        (pause_i),
        .dbg_continue_i (dbg_continue_i),
        .idle_i         (acc_idle),
        .run_o          (run_o),
        .fetch_start_o  (fetch_start_o),
        .fetch_addr_o   (fetch_addr_o),
        .sleep_o        (sleep_o),
        .hibernate_o    (hibernate_o),
        .suspend_o      (suspend_o),
        .paused_o       (paused_o),
        .halted_o       (halted_o)
    );
endmodule

// File: rtl/hwc_checker.sv
// Temporal checks on the halt and wakeup controller, bound to every instance.
// Assumes the access-side protocol described in the brief.
module hwc_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk_i,
    input logic             rst_ns,
    input logic             run_o,
    input logic             fetch_start_o,
    input logic             sleep_o,
    input logic             hibernate_o,
    input logic             suspend_o,
    input logic             paused_o,
    input logic             halted_o,
    input logic             pause_i,
    input logic             dbg_continue_i,
    input logic             acc_req_i,
    input logic             acc_rsp_i,
    input logic [CNT_W-1:0] outstanding
);
    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ns)
        fetch_start_o |=> !fetch_start_o); // R9
    AST_STROBE_WITH_RUN: assert property (@(posedge clk_i) disable iff (!rst_ns)
        fetch_start_o |-> run_o); // R9
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ns)
        $onehot0({sleep_o, hibernate_o, suspend_o})); // R5
    AST_SLEEP_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ns)
        ($rose(sleep_o) || $rose(hibernate_o) || $rose(suspend_o)) |-> (outstanding == '0)); // R4
    AST_RUN_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ns)
        run_o |-> !(sleep_o || hibernate_o || suspend_o || paused_o || halted_o)); // R6
    AST_PAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ns)
        (paused_o && pause_i) |=> (paused_o && !run_o)); // R7
    AST_DHALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ns)
        (halted_o && !dbg_continue_i) |=> halted_o); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ns)
        (acc_rsp_i && !acc_req_i) |-> (outstanding != '0)); // R4
    AST_NO_ACCEPT_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ns)
        acc_req_i |-> run_o); // R4
endmodule

bind halt_wake_ctrl hwc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ns         (rst_n_s),
    .run_o          (run_o),
    .fetch_start_o  (fetch_start_o),
    .sleep_o        (sleep_o),
    .hibernate_o    (hibernate_o),
    .suspend_o      (suspend_o),
    .paused_o       (paused_o),
    .halted_o       (halted_o),
    .pause_i        (pause_i),
    .dbg_continue_i (dbg_continue_i),
    .acc_req_i      (acc_req_i),
    .acc_rsp_i      (acc_rsp_i),
    .outstanding    (acc_cnt)
);

// File: tb/halt_wake_ctrl_bench.sv
// Self-checking bench: directed boot, pause and debug cases, then seeded random sleep cycles.
module halt_wake_ctrl_bench;
    localparam logic [31:0] BASE = 32'h0000_0100;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [1:0]  boot_mode_i = 2'b00;
    logic [1:0]  wake_i = 2'b00;
    logic        sleep_req_i = 1'b0;
    logic [1:0]  sleep_kind_i = 2'b00;
    logic [31:0] resume_addr_i = '0;
    logic        pause_i = 1'b0;
    logic        dbg_continue_i = 1'b0;
    logic        acc_req_i = 1'b0;
    logic        acc_rsp_i = 1'b0;
    logic        run_o, fetch_start_o, sleep_o, hibernate_o, suspend_o, paused_o, halted_o;
    logic [31:0] fetch_addr_o;
    logic        nd_run, nd_fetch, nd_sl, nd_hb, nd_sp, nd_pa, nd_ha;
    logic [31:0] nd_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk_i = ~clk_i;

    halt_wake_ctrl u_halt_wake_ctrl (
        .clk_i, .rst_ni, .boot_mode_i, .wake_i, .sleep_req_i, .sleep_kind_i,
        .resume_addr_i, .pause_i, .dbg_continue_i, .acc_req_i, .acc_rsp_i,
        .run_o, .fetch_start_o, .fetch_addr_o, .sleep_o, .hibernate_o,
        .suspend_o, .paused_o, .halted_o
    );

    // Second instance with debug disabled, checked only around boot.
    halt_wake_ctrl #(.DBG_EN(1'b0)) u_halt_wake_ctrl_nd (
        .clk_i, .rst_ni, .boot_mode_i, .wake_i, .sleep_req_i, .sleep_kind_i,
        .resume_addr_i, .pause_i, .dbg_continue_i, .acc_req_i, .acc_rsp_i,
        .run_o(nd_run), .fetch_start_o(nd_fetch), .fetch_addr_o(nd_addr),
        .sleep_o(nd_sl), .hibernate_o(nd_hb), .suspend_o(nd_sp),
        .paused_o(nd_pa), .halted_o(nd_ha)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected {sleep, hibernate, suspend} for a kind code.
    function automatic logic [2:0] exp_flags(input logic [1:0] k);
        case (k)
            2'b01:   return 3'b010;
            2'b10:   return 3'b001;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [2:0] flags();
        return {sleep_o, hibernate_o, suspend_o};
    endfunction

    task automatic boot(input logic [1:0] mode);
        @(negedge clk_i);
        rst_ni = 1'b0;
        boot_mode_i = mode;
        repeat (4) @(negedge clk_i);
        chk("R1 reset run", {31'd0, run_o}, 32'd0);
        chk("R1 reset status", {27'd0, flags(), paused_o, halted_o}, 32'd0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        chk("R10 reset sync latency", {30'd0, run_o, halted_o | sleep_o}, 32'd0);
        @(negedge clk_i);
    endtask

    // Seeded random sleep/wake cycle with the given outstanding count.
    task automatic sleep_cycle(input int n, input logic [1:0] kind, input logic [31:0] pc,
                               input logic pz, input logic [1:0] wk);
        repeat (3) @(negedge clk_i);
        for (int i = 0; i < n; i++) begin
            acc_req_i = 1'b1;
            @(negedge clk_i);
            acc_req_i = 1'b0;
        end
        sleep_req_i = 1'b1;
        sleep_kind_i = kind;
        resume_addr_i = pc;
        @(negedge clk_i);
        sleep_req_i = 1'b0;
        resume_addr_i = $urandom;
        chk("R4 run drops after request", {31'd0, run_o}, 32'd0);
        for (int i = 0; i < n; i++) begin
            chk("R4 no flag while outstanding", {29'd0, flags()}, 32'd0);
            acc_rsp_i = 1'b1;
            @(negedge clk_i);
            acc_rsp_i = 1'b0;
        end
        chk("R4 still draining", {29'd0, flags()}, 32'd0);
        @(negedge clk_i);
        chk("R5 sleep kind flags", {29'd0, flags()}, {29'd0, exp_flags(kind)});
        pause_i = pz;
        repeat (2) @(negedge clk_i);
        chk("R8 pause ignored in sleep", {29'd0, flags()}, {29'd0, exp_flags(kind)});
        chk("R8 no paused in sleep", {31'd0, paused_o}, 32'd0);
        wake_i = wk;
        repeat (2) @(negedge clk_i);
        chk("R10 wake not yet seen", {31'd0, run_o | paused_o}, 32'd0);
        @(negedge clk_i);
        wake_i = 2'b00;
        if (pz) begin
            chk("R8 wake into pause", {29'd0, paused_o, run_o, fetch_start_o}, 32'b100);
            chk("R8 flags cleared", {29'd0, flags()}, 32'd0);
            pause_i = 1'b0;
            @(negedge clk_i);
            chk("R8 pending start strobe", {30'd0, run_o, fetch_start_o}, 32'b11);
        end else begin
            chk("R6 wake start", {30'd0, run_o, fetch_start_o}, 32'b11);
            chk("R6 flags clear with run", {29'd0, flags()}, 32'd0);
        end
        chk("R6 resume address", fetch_addr_o, pc);
        @(negedge clk_i);
        chk("R9 strobe one cycle", {31'd0, fetch_start_o}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // Boot mode 00.
        boot(2'b00);
        chk("R1 mode00 start", {30'd0, run_o, fetch_start_o}, 32'b11);
        chk("R1 mode00 addr", fetch_addr_o, BASE);
        @(negedge clk_i);
        chk("R9 single strobe", {30'd0, run_o, fetch_start_o}, 32'b10);
        // Pause while running.
        pause_i = 1'b1;
        @(negedge clk_i);
        chk("R7 pause halts", {30'd0, run_o, paused_o}, 32'b01);
        repeat (4) @(negedge clk_i);
        chk("R7 pause level held", {30'd0, run_o, paused_o}, 32'b01);
        pause_i = 1'b0;
        @(negedge clk_i);
        chk("R7 release no strobe", {29'd0, run_o, paused_o, fetch_start_o}, 32'b100);
        // Debug continue outside debug halt.
        dbg_continue_i = 1'b1;
        @(negedge clk_i);
        dbg_continue_i = 1'b0;
        chk("R11 continue ignored", {30'd0, run_o, fetch_start_o}, 32'b10);
        // Boot mode 11.
        boot(2'b11);
        chk("R1 mode11 start", {30'd0, run_o, fetch_start_o}, 32'b11);
        chk("R1 mode11 addr", fetch_addr_o, BASE);
        // Boot mode 01 then wake on bit 1.
        boot(2'b01);
        chk("R2 boot sleep", {28'd0, flags(), run_o}, 32'b1000);
        dbg_continue_i = 1'b1;
        @(negedge clk_i);
        dbg_continue_i = 1'b0;
        chk("R11 continue ignored in sleep", {28'd0, flags(), fetch_start_o}, 32'b1000);
        wake_i = 2'b10;
        repeat (2) @(negedge clk_i);
        chk("R10 wake latency", {31'd0, run_o}, 32'd0);
        @(negedge clk_i);
        wake_i = 2'b00;
        chk("R2 wake start", {30'd0, run_o, fetch_start_o}, 32'b11);
        chk("R2 wake addr", fetch_addr_o, BASE);
        chk("R6 boot flags cleared", {29'd0, flags()}, 32'd0);
        // Boot mode 10.
        boot(2'b10);
        chk("R3 debug halt", {30'd0, halted_o, run_o}, 32'b10);
        chk("R3 no-debug variant runs", {30'd0, nd_run, nd_fetch}, 32'b11);
        chk("R3 no-debug variant addr", nd_addr, BASE);
        repeat (3) @(negedge clk_i);
        chk("R3 halt holds", {30'd0, halted_o, fetch_start_o}, 32'b10);
        dbg_continue_i = 1'b1;
        @(negedge clk_i);
        dbg_continue_i = 1'b0;
        chk("R3 continue start", {29'd0, halted_o, run_o, fetch_start_o}, 32'b011);
        chk("R3 continue addr", fetch_addr_o, BASE);
        // Directed corner: kind 11 and max-ish outstanding with pause at wake.
        sleep_cycle(4, 2'b11, 32'hDEAD_BEE0, 1'b1, 2'b01);
        sleep_cycle(0, 2'b01, 32'h0000_0004, 1'b0, 2'b11);
        // Seeded random cycles.
        for (int it = 0; it < 24; it++) begin
            sleep_cycle(int'($urandom % 5), 2'($urandom % 4), $urandom & 32'hFFFF_FFFC,
                        1'($urandom % 2), ($urandom % 2) ? 2'b01 : 2'b10);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule